// File: doc/BRIEF.md
# Self-Learning Relay Switching Controller

This block drives a three-state relay (positive drive, negative drive, open) for a second-order positioning loop. It aims to settle each disturbance with a single, well-timed reversal. A strobe announces each new error sample. The block takes the absolute difference between this sample and the one before it as its only measure of speed, so it never works out an error rate.

While the drive pushes the error back after the first reversal, the controller records the error it sees into a small table. The table is indexed by that absolute difference. This builds the curve along which the loop comes to rest. On later disturbances it compares the live error with the stored curve, shifted by the resting point, and reverses the relay where the two meet. A four-state phase register decides, sample by sample, whether to learn, compare or coast. If the error magnitude grows past the resting point after a reversal, the reversal was early, most likely because the plant has changed. The block then reverses again and relearns the curve.

Top module: `relay_learn_ctrl`

## Requirements
- R1: A strobe that arrives while no sample is pending is captured on the next clock edge. Its effect shows on the outputs after the edge that follows. Outputs change only on that decision edge.
- R2: A strobe that arrives while a sample is still pending is dropped. It raises `overrun`, which then stays high until reset.
- R3: While the relay is open, a sample whose magnitude exceeds `settle_tol` drives the relay toward the sign of the error. Positive error gives `drv_en`=1, `drv_pos`=1. Negative error gives `drv_en`=1, `drv_pos`=0. The phase goes to 0 and the sample's magnitude is kept as the initial magnitude.
- R4: In phase 0, an error whose sign is opposite to the drive reverses the relay and moves the phase to 1.
- R5: In phase 1, each sample with difference d ≤ MAX_DIFF stores its signed error at table entry d, and also at entry d-1 when d > 0. A difference above MAX_DIFF stores nothing.
- R6: In phase 1, a sample with difference 0 ends learning. Its error magnitude becomes the rest offset and the phase goes to 2.
- R7: A compare hits when entries d and 0 are both filled and |error| ≤ |entry[d] − entry[0]|. A hit reverses the relay and sets phase 3. An empty entry, or d > MAX_DIFF, never hits.
- R8: In phase 0, the compare is armed only while |error| is below the initial magnitude. An armed hit takes precedence over the sign-change reversal.
- R9: In phase 3, an error magnitude above the rest offset reverses the relay and sets phase 1. At reset the offset is preset to its maximum.
- R10: While the relay drives, a sample with both |error| and the difference at or below `settle_tol` opens the relay and returns the phase to 0. This check comes before any other decision.
- R11: After reset the relay is open, the phase is 0, `overrun` is low and every table entry is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | New error sample strobe |
| smp_err | input | ERR_W | Signed error sample |
| settle_tol | input | ERR_W | Unsigned settling tolerance |
| drv_en | output | 1 | Relay energised |
| drv_pos | output | 1 | Drive polarity, 1 = positive |
| phase | output | 2 | Current phase index |
| overrun | output | 1 | Sticky dropped-strobe flag |

## Verification
The hardest state to reach from the ports is the early-switch recovery. It needs a learned table and a compare hit from that table, then an error that grows again past the learned rest offset. The stimulus therefore runs a full learning response, then a second response shaped to hit the stored curve early and then swing outward, and then lets learning finish again. A behavioural model runs alongside and follows a long pseudo-random error walk, so that out-of-range differences, empty entries and copied neighbour entries are all compared on every clock.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_POS = 2'd1,
        DRV_NEG = 2'd2
    } drive_e;

    typedef enum logic [1:0] {
        PH_SEEK  = 2'd0,
        PH_LEARN = 2'd1,
        PH_HUNT  = 2'd2,
        PH_COAST = 2'd3
    } phase_e;

    function automatic drive_e drive_flip(drive_e d);
        return (d == DRV_POS) ? DRV_NEG : DRV_POS;
    endfunction

endpackage

// File: rtl/rlc_sample.sv
module rlc_sample #(
    parameter int ERR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stb,
    input  logic signed [ERR_W-1:0] err_in,
    output logic                    pend,
    output logic signed [ERR_W-1:0] cur_err,
    output logic [ERR_W:0]          diff_mag,
    output logic                    overrun
);
    localparam int EXT_W = ERR_W + 1;

    logic                    pend_q;
    logic                    ovr_q;
    logic signed [ERR_W-1:0] cur_q;
    logic signed [ERR_W-1:0] prev_q;
    logic signed [EXT_W-1:0] delta;

    assign delta    = EXT_W'(cur_q) - EXT_W'(prev_q);
    assign diff_mag = delta[EXT_W-1] ? $unsigned(-delta) : $unsigned(delta);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            if (pend_q) begin
                prev_q <= cur_q;
                pend_q <= 1'b0;
                if (stb) ovr_q <= 1'b1;
            end else if (stb) begin
                pend_q <= 1'b1;
                cur_q  <= err_in;
            end
        end
    end

    assign pend    = pend_q;
    assign cur_err = cur_q;
    assign overrun = ovr_q;

    // R2
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q);

    // R1
    one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> !pend_q);

endmodule

// File: rtl/rlc_curve_table.sv
module rlc_curve_table #(
    parameter int ERR_W    = 12,
    parameter int MAX_DIFF = 60
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ERR_W:0]          wr_addr,
    input  logic signed [ERR_W-1:0] wr_data,
    input  logic [ERR_W:0]          rd_addr,
    output logic signed [ERR_W-1:0] rd_data,
    output logic                    rd_ok,
    output logic signed [ERR_W-1:0] base_data,
    output logic                    base_ok
);
    localparam int DEPTH = MAX_DIFF + 1;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int EXT_W = ERR_W + 1;

    logic [DEPTH-1:0]        filled;
    logic signed [ERR_W-1:0] entry [DEPTH];
    logic                    rd_in_range;
    logic [AW-1:0]           rd_idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic hit_here;
        assign hit_here = wr_en && ((wr_addr == EXT_W'(i)) || (wr_addr == EXT_W'(i + 1)));
        always_ff @(posedge clk) begin
            if (rst) begin
                filled[i] <= 1'b0;
                entry[i]  <= '0;
            end else if (hit_here) begin
                filled[i] <= 1'b1;
                entry[i]  <= wr_data;
            end
        end
    end

    assign rd_in_range = (rd_addr <= EXT_W'(MAX_DIFF));
    assign rd_idx      = rd_in_range ? rd_addr[AW-1:0] : '0;
    assign rd_ok       = rd_in_range && filled[rd_idx];
    assign rd_data     = entry[rd_idx];
    assign base_ok     = filled[0];
    assign base_data   = entry[0];

    // R5
    copy_below_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == EXT_W'(1)) |=> (filled[0] && entry[0] == $past(wr_data)));

endmodule

// File: rtl/rlc_decide.sv
module rlc_decide
    import rlc_pkg::*;
#(
    parameter int ERR_W    = 12,
    parameter int MAX_DIFF = 60
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld,
    input  logic signed [ERR_W-1:0] cur_err,
    input  logic [ERR_W:0]          diff_mag,
    input  logic [ERR_W-1:0]        tol,
    input  logic signed [ERR_W-1:0] tab_data,
    input  logic                    tab_ok,
    input  logic signed [ERR_W-1:0] base_data,
    input  logic                    base_ok,
    output logic                    wr_en,
    output drive_e                  drive,
    output phase_e                  phase
);
    localparam int EXT_W = ERR_W + 1;

    drive_e              drive_q, drive_n;
    phase_e              phase_q, phase_n;
    logic [EXT_W-1:0]    init_q, init_n;
    logic [EXT_W-1:0]    off_q, off_n;

    logic signed [EXT_W-1:0] cur_ext;
    logic [EXT_W-1:0]        cur_mag;
    logic [EXT_W-1:0]        tol_x;
    logic signed [EXT_W-1:0] gap;
    logic [EXT_W-1:0]        thr;
    logic                    in_range;
    logic                    hit;
    logic                    crossed;
    logic                    settled;

    assign cur_ext  = EXT_W'(cur_err);
    assign cur_mag  = cur_ext[EXT_W-1] ? $unsigned(-cur_ext) : $unsigned(cur_ext);
    assign tol_x    = EXT_W'(tol);
    assign gap      = EXT_W'(tab_data) - EXT_W'(base_data);
    assign thr      = gap[EXT_W-1] ? $unsigned(-gap) : $unsigned(gap);
    assign in_range = (diff_mag <= EXT_W'(MAX_DIFF));
    assign hit      = in_range && tab_ok && base_ok && (cur_mag <= thr);
    assign crossed  = ((drive_q == DRV_POS) && (cur_err < 0)) ||
                      ((drive_q == DRV_NEG) && (cur_err > 0));
    assign settled  = (cur_mag <= tol_x) && (diff_mag <= tol_x);

    always_comb begin
        drive_n = drive_q;
        phase_n = phase_q;
        init_n  = init_q;
        off_n   = off_q;
        wr_en   = 1'b0;
        if (vld) begin
            if (drive_q == DRV_OFF) begin
                if (cur_mag > tol_x) begin
                    drive_n = cur_err[ERR_W-1] ? DRV_NEG : DRV_POS;
                    phase_n = PH_SEEK;
                    init_n  = cur_mag;
                end
            end else if (settled) begin
                drive_n = DRV_OFF;
                phase_n = PH_SEEK;
            end else begin
                case (phase_q)
                    PH_SEEK: begin
                        if ((cur_mag < init_q) && hit) begin
                            drive_n = drive_flip(drive_q);
                            phase_n = PH_COAST;
                        end else if (crossed) begin
                            drive_n = drive_flip(drive_q);
                            phase_n = PH_LEARN;
                        end
                    end
                    PH_LEARN: begin
                        wr_en = in_range;
                        if (diff_mag == '0) begin
                            off_n   = cur_mag;
                            phase_n = PH_HUNT;
                        end
                    end
                    PH_HUNT: begin
                        if (hit) begin
                            drive_n = drive_flip(drive_q);
                            phase_n = PH_COAST;
                        end
                    end
                    default: begin
                        if (cur_mag > off_q) begin
                            drive_n = drive_flip(drive_q);
                            phase_n = PH_LEARN;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= DRV_OFF;
            phase_q <= PH_SEEK;
            init_q  <= '0;
            off_q   <= '1;
        end else begin
            drive_q <= drive_n;
            phase_q <= phase_n;
            init_q  <= init_n;
            off_q   <= off_n;
        end
    end

    assign drive = drive_q;
    assign phase = phase_q;

    // R10
    idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_q == DRV_OFF) |-> (phase_q == PH_SEEK));

    // R1
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> ($stable(drive_q) && $stable(phase_q)));

    // R9
    coast_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_COAST) |=> (phase_q != PH_HUNT));

    // R6
    learn_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (phase_q == PH_LEARN && vld));

endmodule

// File: rtl/relay_learn_ctrl.sv
module relay_learn_ctrl
    import rlc_pkg::*;
#(
    parameter int ERR_W    = 12,
    parameter int MAX_DIFF = 60
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_stb,
    input  logic signed [ERR_W-1:0] smp_err,
    input  logic [ERR_W-1:0]        settle_tol,
    output logic                    drv_en,
    output logic                    drv_pos,
    output logic [1:0]              phase,
    output logic                    overrun
);
    logic                    pend;
    logic signed [ERR_W-1:0] cur_err;
    logic [ERR_W:0]          diff_mag;
    logic                    wr_en;
    logic signed [ERR_W-1:0] tab_data;
    logic                    tab_ok;
    logic signed [ERR_W-1:0] base_data;
    logic                    base_ok;
    drive_e                  drive;
    phase_e                  ph;

    rlc_sample #(.ERR_W(ERR_W)) u_sample (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_stb),
        .err_in   (smp_err),
        .pend     (pend),
        .cur_err  (cur_err),
        .diff_mag (diff_mag),
        .overrun  (overrun)
    );

    rlc_curve_table #(.ERR_W(ERR_W), .MAX_DIFF(MAX_DIFF)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (diff_mag),
        .wr_data   (cur_err),
        .rd_addr   (diff_mag),
        .rd_data   (tab_data),
        .rd_ok     (tab_ok),
        .base_data (base_data),
        .base_ok   (base_ok)
    );

    rlc_decide #(.ERR_W(ERR_W), .MAX_DIFF(MAX_DIFF)) u_decide (
        .clk       (clk),
        .rst       (rst),
        .vld       (pend),
        .cur_err   (cur_err),
        .diff_mag  (diff_mag),
        .tol       (settle_tol),
        .tab_data  (tab_data),
        .tab_ok    (tab_ok),
        .base_data (base_data),
        .base_ok   (base_ok),
        .wr_en     (wr_en),
        .drive     (drive),
        .phase     (ph)
    );

    assign drv_en  = (drive != DRV_OFF);
    assign drv_pos = (drive == DRV_POS);
    assign phase   = ph;

    // R3
    drive_enc_chk: assert property (@(posedge clk) disable iff (rst)
        drv_pos |-> drv_en);

endmodule

// File: tb/relay_learn_ctrl_test.sv
`timescale 1ns/1ps
module relay_learn_ctrl_test;
    localparam int ERR_W = 12;
    localparam int MAXD  = 60;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    smp_stb = 1'b0;
    logic signed [ERR_W-1:0] smp_err = '0;
    logic [ERR_W-1:0]        settle_tol = 12'd2;
    logic                    drv_en, drv_pos, overrun;
    logic [1:0]              phase;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit started = 0;

    always #2 clk = ~clk;

    relay_learn_ctrl #(.ERR_W(ERR_W), .MAX_DIFF(MAXD)) uut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_err(smp_err),
        .settle_tol(settle_tol), .drv_en(drv_en), .drv_pos(drv_pos),
        .phase(phase), .overrun(overrun)
    );

    // behavioural reference: drive 0 open, 1 positive, 2 negative
    int m_drv = 0, m_ph = 0, m_init = 0, m_off = 1 << 30, m_prev = 0;
    int m_tab [MAXD+1];
    bit m_ok  [MAXD+1];
    bit m_pend = 0, m_ovr = 0;
    int m_cur = 0;

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic m_clear();
        m_drv = 0; m_ph = 0; m_init = 0; m_off = 1 << 30; m_prev = 0;
        m_pend = 0; m_ovr = 0; m_cur = 0;
        for (int i = 0; i <= MAXD; i++) begin m_ok[i] = 0; m_tab[i] = 0; end
    endtask

    task automatic m_step(int e);
        int d, ae, tl;
        bit hit;
        d = iabs(e - m_prev);
        m_prev = e;
        ae = iabs(e);
        tl = int'(settle_tol);
        hit = 0;
        if (d <= MAXD) hit = m_ok[d] && m_ok[0] && (ae <= iabs(m_tab[d] - m_tab[0]));
        if (m_drv == 0) begin
            if (ae > tl) begin m_drv = (e < 0) ? 2 : 1; m_ph = 0; m_init = ae; end
        end else if (ae <= tl && d <= tl) begin
            m_drv = 0; m_ph = 0;
        end else if (m_ph == 0) begin
            if (ae < m_init && hit) begin m_drv = 3 - m_drv; m_ph = 3; end
            else if ((m_drv == 1 && e < 0) || (m_drv == 2 && e > 0)) begin m_drv = 3 - m_drv; m_ph = 1; end
        end else if (m_ph == 1) begin
            if (d <= MAXD) begin
                m_tab[d] = e; m_ok[d] = 1;
                if (d > 0) begin m_tab[d-1] = e; m_ok[d-1] = 1; end
            end
            if (d == 0) begin m_off = ae; m_ph = 2; end
        end else if (m_ph == 2) begin
            if (hit) begin m_drv = 3 - m_drv; m_ph = 3; end
        end else begin
            if (ae > m_off) begin m_drv = 3 - m_drv; m_ph = 1; end
        end
    endtask

    always @(posedge clk) begin
        bit was;
        cyc++;
        if (rst) begin
            m_clear();
            started = 1;
        end else begin
            was = m_pend;
            m_pend = 0;
            if (was) m_step(m_cur);
            if (smp_stb) begin
                if (was) m_ovr = 1;
                else begin m_pend = 1; m_cur = int'(smp_err); end
            end
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R1 watchdog expired: actual cycles %0d expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-clock comparison with the model, sampled mid-cycle
    always @(negedge clk) begin
        if (started && !rst) begin
            chk("R1 drive enable vs model", int'(drv_en), int'(m_drv != 0));
            chk("R1 drive polarity vs model", int'(drv_pos), int'(m_drv == 1));
            chk("R1 phase vs model", int'(phase), m_ph);
            chk("R2 overrun vs model", int'(overrun), int'(m_ovr));
        end
    end

    task automatic send(int e);
        smp_stb = 1'b1;
        smp_err = ERR_W'(e);
        @(negedge clk);
        smp_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_st(string tag, int en, int pos, int ph);
        chk({tag, " en"}, int'(drv_en), en);
        chk({tag, " pos"}, int'(drv_pos), pos);
        chk({tag, " phase"}, int'(phase), ph);
    endtask

    initial begin
        int e;
        int s;
        settle_tol = 12'd2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_st("R11 reset", 0, 0, 0);
        chk("R11 reset overrun", int'(overrun), 0);

        // first response: learn the curve
        send(200);  expect_st("R3 start positive", 1, 1, 0);
        send(190);  expect_st("R7 empty table no switch", 1, 1, 0);
        send(150); send(100); send(50);
        send(-5);   expect_st("R4 sign reversal", 1, 0, 1);
        send(-25); send(-40); send(-50); send(-55); send(-57);
        expect_st("R5 still learning", 1, 0, 1);
        send(-57);  expect_st("R6 learning ends", 1, 0, 2);
        send(-40);  expect_st("R7 empty entry no switch", 1, 0, 2);
        send(-25);  expect_st("R7 above threshold", 1, 0, 2);
        send(-5);   expect_st("R7 compare hit", 1, 1, 3);
        send(2);    expect_st("R10 diff too large", 1, 1, 3);
        send(1);    expect_st("R10 settle opens", 0, 0, 0);

        // second response: optimum hit, early-switch recovery, relearn
        send(150);  expect_st("R3 restart", 1, 1, 0);
        send(140);  expect_st("R7 below-threshold miss", 1, 1, 0);
        send(120); send(90); send(60); send(30);
        send(10);   expect_st("R8 armed hit", 1, 0, 3);
        send(20);   expect_st("R9 within offset", 1, 0, 3);
        send(70);   expect_st("R9 early switch", 1, 1, 1);
        send(75);
        send(75);   expect_st("R6 relearn ends", 1, 1, 2);
        send(1);    expect_st("R7 diff out of range", 1, 1, 2);
        send(0);    expect_st("R10 settle again", 0, 0, 0);

        // arming gate
        send(10);   expect_st("R3 small start", 1, 1, 0);
        send(12);   expect_st("R8 not armed above initial", 1, 1, 0);
        send(-3);   expect_st("R8 compare beats sign", 1, 0, 3);
        send(-1);   expect_st("R10 settle third", 0, 0, 0);

        // negative start
        send(-300); expect_st("R3 start negative", 1, 0, 0);
        send(-1); send(0);

        // pseudo-random walk checked against the model every clock
        settle_tol = 12'd3;
        e = 0;
        s = 12345;
        for (int n = 0; n < 1500; n++) begin
            s = s * 1103515245 + 12345;
            if (((s >>> 16) & 31) == 0) e = ((s >>> 8) & 1023) - 512;
            else e = e + (((s >>> 12) & 127) - 64);
            if (e > 1500) e = 1500;
            if (e < -1500) e = -1500;
            if (n % 47 == 46) begin send(2); send(1); send(1); e = 1; end
            else send(e);
            for (int g = 0; g < ((s >>> 20) & 3); g++) @(negedge clk);
        end

        // overrun: strobe on two consecutive cycles
        chk("R2 no overrun before", int'(overrun), 0);
        smp_stb = 1'b1; smp_err = 12'sd400;
        @(negedge clk);
        smp_err = 12'sd9;
        @(negedge clk);
        smp_stb = 1'b0;
        @(negedge clk);
        chk("R2 overrun raised", int'(overrun), 1);
        repeat (3) @(negedge clk);
        chk("R2 overrun sticky", int'(overrun), 1);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_st("R11 second reset", 0, 0, 0);
        chk("R11 overrun cleared", int'(overrun), 0);
        send(-5);
        send(-4);   expect_st("R11 table empty after reset", 1, 0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule